// File: doc/BRIEF.md
# Parity-Gated Block Averager

This block is one channel's averaging stage inside an error-estimation unit. Each clock it may receive a three-level sample (+1, 0 or -1) together with a qualifying parity flag. Only samples that arrive with both the strobe and the flag high are taken into a saturating up/down accumulator, and a counter tracks how many have been taken.

When the number of qualifying samples reaches a fixed block length, the accumulated sum is scaled and loaded into the coefficient output. The scaling is an arithmetic right shift by a fixed amount, followed by keeping a few bits. The sum includes the sample that completes the block. The accumulator and the counter then restart from zero. The coefficient holds its value until the next block completes. Every width, the block length and the shift are parameters, so the same block serves channels with different precision.

Top module: `pgavg_top`

## Requirements
- R1: A sample changes the accumulated state only on a clock edge where `smp_vld` and `par_flag` are both 1; on any other edge it has no effect on any later `coef` value.
- R2: `smp_lvl` is read as 2'b01 = +1, 2'b00 = 0, 2'b11 = -1.
- R3: A block completes on the edge that accepts the `BLOCK_LEN`-th qualifying sample since reset or since the previous completion.
- R4: On completion, `coef` takes the low `OUT_W` bits of floor(sum / 2^`SHIFT`), two's complement, where sum is the `ACC_W`-bit signed accumulated value.
- R5: `coef` changes only on the edge that completes a block and holds its value otherwise.
- R6: The synchronous, active-high `rst` drives `coef` to 0, and `coef` stays 0 until the first block completes.
- R7: The accumulator saturates at +(2^(`ACC_W`-1)-1) and -2^(`ACC_W`-1) and does not wrap.
- R8: The sample that completes a block is included in the value written to `coef`. The next block starts from an accumulator of 0 and a count of 0.
- R9: The unused code 2'b10 on `smp_lvl` counts as a qualifying sample of value 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| smp_vld | input | 1 | Sample strobe |
| smp_lvl | input | 2 | Three-level sample code |
| par_flag | input | 1 | Qualifying parity flag |
| coef | output | OUT_W | Scaled block average |

## Verification
The hardest state to reach from the ports is the accumulator sitting at a saturation limit when a block closes. A wrapped sum and a clamped sum differ at `coef` only if a whole block is pushed in one direction. The bench therefore shrinks the accumulator and the block length and drives full blocks of all +1 and all -1 samples. A behavioural reference model, compared with `coef` every cycle, covers the random mixes of strobe, flag and code.

// File: rtl/pgavg_pkg.sv
`timescale 1ns/1ps
package pgavg_pkg;
   typedef enum logic [1:0] {
      LVL_ZERO = 2'b00,
      LVL_POS  = 2'b01,
      LVL_BAD  = 2'b10,
      LVL_NEG  = 2'b11
   } lvl_t;
endpackage

// File: rtl/pgavg_level_dec.sv
`timescale 1ns/1ps
module pgavg_level_dec
   import pgavg_pkg::*;
(
   input  logic [1:0] code,
   output logic       up,
   output logic       down
);
   always_comb begin
      up   = 1'b0;
      down = 1'b0;
      case (lvl_t'(code))
         LVL_POS: up   = 1'b1;
         LVL_NEG: down = 1'b1;
         default: ;
      endcase
   end
endmodule

// File: rtl/pgavg_sat_acc.sv
`timescale 1ns/1ps
module pgavg_sat_acc #(
   parameter int ACC_W = 18
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    take,
   input  logic                    clr,
   input  logic                    up,
   input  logic                    down,
   output logic signed [ACC_W-1:0] acc_nxt
);
   localparam logic signed [ACC_W-1:0] MAXV = {1'b0, {(ACC_W-1){1'b1}}};
   localparam logic signed [ACC_W-1:0] MINV = {1'b1, {(ACC_W-1){1'b0}}};
   localparam logic signed [ACC_W-1:0] ONE  = {{(ACC_W-1){1'b0}}, 1'b1};

   logic signed [ACC_W-1:0] acc_q;

   always_comb begin
      acc_nxt = acc_q;
      if (up && acc_q != MAXV)
         acc_nxt = acc_q + ONE;
      else if (down && acc_q != MINV)
         acc_nxt = acc_q - ONE;
   end

   always_ff @(posedge clk) begin
      if (rst)
         acc_q <= '0;
      else if (take)
         acc_q <= clr ? '0 : acc_nxt;
   end

   // R1: no qualifying sample, no change
   assert_acc_ignore_R1: assert property (@(posedge clk) disable iff (rst)
      !$past(take) |-> $stable(acc_q));
   // R8: new block starts from zero
   assert_acc_clear_R8: assert property (@(posedge clk) disable iff (rst)
      ($past(take) && $past(clr)) |-> acc_q == '0);
   // R7: clamp at the upper limit
   assert_acc_sat_hi_R7: assert property (@(posedge clk) disable iff (rst)
      ($past(acc_q) == MAXV && $past(take) && !$past(clr) && $past(up)) |-> acc_q == MAXV);
   // R7: clamp at the lower limit
   assert_acc_sat_lo_R7: assert property (@(posedge clk) disable iff (rst)
      ($past(acc_q) == MINV && $past(take) && !$past(clr) && $past(down)) |-> acc_q == MINV);
endmodule

// File: rtl/pgavg_blk_cnt.sv
`timescale 1ns/1ps
module pgavg_blk_cnt #(
   parameter int CNT_W     = 25,
   parameter int BLOCK_LEN = 1 << 25
) (
   input  logic clk,
   input  logic rst,
   input  logic take,
   output logic last
);
   localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(BLOCK_LEN - 1);
   localparam logic [CNT_W-1:0] ONE      = {{(CNT_W-1){1'b0}}, 1'b1};

   logic [CNT_W-1:0] cnt_q;

   assign last = take && (cnt_q == LAST_IDX);

   always_ff @(posedge clk) begin
      if (rst)
         cnt_q <= '0;
      else if (take)
         cnt_q <= last ? '0 : cnt_q + ONE;
   end

   // R3: count never passes the block length
   assert_cnt_range_R3: assert property (@(posedge clk) disable iff (rst)
      cnt_q <= LAST_IDX);
endmodule

// File: rtl/pgavg_scale.sv
`timescale 1ns/1ps
module pgavg_scale #(
   parameter int ACC_W = 18,
   parameter int SHIFT = 15,
   parameter int OUT_W = 5
) (
   input  logic signed [ACC_W-1:0] sum,
   output logic        [OUT_W-1:0] scaled
);
   localparam int KEEP = ACC_W - SHIFT;

   generate
      if (KEEP >= OUT_W) begin : g_trunc
         assign scaled = sum[SHIFT +: OUT_W];
      end else begin : g_sext
         assign scaled = {{(OUT_W-KEEP){sum[ACC_W-1]}}, sum[ACC_W-1:SHIFT]};
      end
   endgenerate
endmodule

// File: rtl/pgavg_top.sv
`timescale 1ns/1ps
module pgavg_top #(
   parameter int ACC_W     = 18,
   parameter int CNT_W     = 25,
   parameter int BLOCK_LEN = 1 << 25,
   parameter int SHIFT     = 15,
   parameter int OUT_W     = 5
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             smp_vld,
   input  logic [1:0]       smp_lvl,
   input  logic             par_flag,
   output logic [OUT_W-1:0] coef
);
   generate
      if (ACC_W < 2)                      begin : g_bad_acc  $error("ACC_W must be at least 2"); end
      if (SHIFT < 0 || SHIFT >= ACC_W)    begin : g_bad_sh   $error("SHIFT out of range"); end
      if (OUT_W < 1)                      begin : g_bad_out  $error("OUT_W must be positive"); end
      if (CNT_W < 1 || CNT_W > 31)        begin : g_bad_cw   $error("CNT_W out of range"); end
      if (BLOCK_LEN < 1 || longint'(BLOCK_LEN) > (64'sd1 << CNT_W))
                                          begin : g_bad_len  $error("BLOCK_LEN does not fit CNT_W"); end
   endgenerate

   logic                    take;
   logic                    up, down;
   logic                    last;
   logic signed [ACC_W-1:0] acc_nxt;
   logic        [OUT_W-1:0] scaled;
   logic                    upd_q;

   assign take = smp_vld && par_flag;

   pgavg_level_dec u_dec (
      .code (smp_lvl),
      .up   (up),
      .down (down)
   );

   pgavg_blk_cnt #(.CNT_W(CNT_W), .BLOCK_LEN(BLOCK_LEN)) u_cnt (
      .clk  (clk),
      .rst  (rst),
      .take (take),
      .last (last)
   );

   pgavg_sat_acc #(.ACC_W(ACC_W)) u_acc (
      .clk     (clk),
      .rst     (rst),
      .take    (take),
      .clr     (last),
      .up      (up),
      .down    (down),
      .acc_nxt (acc_nxt)
   );

   pgavg_scale #(.ACC_W(ACC_W), .SHIFT(SHIFT), .OUT_W(OUT_W)) u_scale (
      .sum    (acc_nxt),
      .scaled (scaled)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         coef  <= '0;
         upd_q <= 1'b0;
      end else begin
         upd_q <= last;
         if (last)
            coef <= scaled;
      end
   end

   // R5: output moves only right after a completed block
   assert_coef_hold_R5: assert property (@(posedge clk) disable iff (rst)
      (coef != $past(coef)) |-> upd_q);
   // R1: a completion needs a qualifying sample
   assert_upd_needs_take_R1: assert property (@(posedge clk) disable iff (rst)
      upd_q |-> ($past(smp_vld) && $past(par_flag)));
endmodule

// File: tb/pgavg_top_tb_top.sv
`timescale 1ns/1ps
module pgavg_top_tb_top;
   localparam int ACC_W = 6;
   localparam int CNT_W = 6;
   localparam int BLEN  = 40;
   localparam int SH    = 2;
   localparam int OW    = 5;
   localparam int AMAX  = (1 << (ACC_W-1)) - 1;
   localparam int AMIN  = -(1 << (ACC_W-1));

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          smp_vld = 1'b0;
   logic [1:0]    smp_lvl = 2'b00;
   logic          par_flag = 1'b0;
   logic [OW-1:0] coef;

   int checks = 0;
   int fails  = 0;
   int m_acc  = 0;
   int m_cnt  = 0;
   logic [OW-1:0] m_out = '0;
   bit done = 0;

   always #2.5 clk = ~clk;

   pgavg_top #(.ACC_W(ACC_W), .CNT_W(CNT_W), .BLOCK_LEN(BLEN), .SHIFT(SH), .OUT_W(OW)) dut_i (
      .clk      (clk),
      .rst      (rst),
      .smp_vld  (smp_vld),
      .smp_lvl  (smp_lvl),
      .par_flag (par_flag),
      .coef     (coef)
   );

   task automatic check(string tag);
      checks++;
      if (coef !== m_out) begin
         fails++;
         $display("FAIL %s: coef actual %b expected %b", tag, coef, m_out);
      end
   endtask

   // one clock: drive on the falling edge, update the model, compare after the rising edge
   task automatic step(bit v, bit p, logic [1:0] c, string tag);
      int d, s;
      @(negedge clk);
      smp_vld = v; par_flag = p; smp_lvl = c;
      if (v && p) begin
         d = (c == 2'b01) ? 1 : (c == 2'b11) ? -1 : 0;
         s = m_acc + d;
         if (s > AMAX) s = AMAX;
         if (s < AMIN) s = AMIN;
         m_cnt++;
         if (m_cnt == BLEN) begin
            m_out = OW'((s >>> SH) & ((1 << OW) - 1));
            m_acc = 0;
            m_cnt = 0;
         end else begin
            m_acc = s;
         end
      end
      @(posedge clk);
      #1;
      check(tag);
   endtask

   initial begin
      repeat (4) @(posedge clk);
      #1;
      check("R6 reset");
      @(negedge clk);
      rst = 1'b0;
      // R1: strobe or flag low, nothing accumulates
      for (int i = 0; i < 60; i++) step(i[0], ~i[0], 2'b01, "R1 gated");
      // R6: still zero before first block
      for (int i = 0; i < BLEN-1; i++) step(1'b1, 1'b1, 2'b00, "R6 pre-block");
      // R8 R3: last sample is +1 and closes the block
      step(1'b1, 1'b1, 2'b01, "R8 final sample");
      // R7 R2: full block of +1 saturates the sum
      for (int i = 0; i < BLEN; i++) step(1'b1, 1'b1, 2'b01, "R7 sat high");
      // R5: hold while flag is low
      for (int i = 0; i < 30; i++) step(1'b1, 1'b0, 2'b11, "R5 hold");
      // R7 R2: full block of -1
      for (int i = 0; i < BLEN; i++) step(1'b1, 1'b1, 2'b11, "R7 sat low");
      // R9: unused code is a zero-valued qualifying sample
      for (int i = 0; i < BLEN; i++) step(1'b1, 1'b1, (i < 10) ? 2'b01 : 2'b10, "R9 code 10");
      // R4 R3 R1: random mixes of strobe, flag and code
      for (int i = 0; i < 4000; i++)
         step(1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 1)),
              2'($urandom_range(0, 3)), "R4 random");
      // R4: biased mix keeps the sum unsaturated
      for (int i = 0; i < 800; i++)
         step(1'b1, 1'b1, ($urandom_range(0, 9) < 6) ? 2'b01 : 2'b11, "R4 biased");
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #(5.0 * 200000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule